// File: doc/BRIEF.md
# Receive Frame Admission Filter

This block sits at the end of an Ethernet receive path and decides, once per frame, whether the frame is handed to the client. The surrounding logic presents one frame summary per cycle: the 48-bit destination address, whether the frame is a MAC control frame and its 16-bit opcode, the top bits of the frame CRC and an error indication. One cycle later the block returns a verdict: accept (with or without an error flag) or drop.

The filter has four parts. Two exact-match station addresses admit unicast traffic. A 512-bit hash table, indexed by the upper nine CRC bits, admits multicast traffic. Promiscuous mode admits all data frames. Separate policy bits cover pause frames, other control frames and errored frames. The station addresses are loaded one 32-bit or 16-bit word at a time. The hash table is written one entry at a time, or cleared in a single cycle. The block computes no CRC and stores no frame data.

The destination address is packed with the first octet on the wire in bits 47:40. This places the group (multicast) bit at bit 40.

Top module: `rx_frame_filter`

## Requirements
- R1: The verdict is registered. `dec_valid` is high exactly in the cycle after a cycle with `frm_valid` high. When it is high, exactly one of `dec_accept` and `dec_drop` is high. When it is low, `dec_accept`, `dec_drop` and `dec_err_flag` are all low. After reset all four outputs are low.
- R2: With `cfg_promisc` set, every non-control frame that passes the error rule of R10 is accepted, whatever its destination.
- R3: A non-control frame whose destination is all ones (broadcast) passes address filtering in every mode.
- R4: A non-control frame with bit 40 of the destination clear (unicast) passes address filtering without promiscuous mode only if it equals one of the two station addresses. A station write with `sta_wr_upper` clear loads address bits 31:0 from `sta_wr_data[31:0]`. A write with `sta_wr_upper` set loads bits 47:32 from `sta_wr_data[15:0]`. `sta_wr_sel` picks the station. Both stations reset to zero.
- R5: A non-control frame with bit 40 set that is not broadcast passes address filtering without promiscuous mode only if the hash entry at index `frm_crc_hi` (CRC bits 31:23) is set. All entries reset to zero.
- R6: A hash write sets the entry at `hash_wr_cmd[8:0]` to the value of `hash_wr_cmd[9]`. Frames presented in any later cycle see the new value.
- R7: `hash_clr_all` clears all 512 entries. In the same cycle it overrides a hash write.
- R8: A control frame with opcode 0x0001 (pause) bypasses address filtering. It passes only when `cfg_pause_fwd` is set and is dropped otherwise.
- R9: A control frame with any other opcode bypasses address filtering and passes only when `cfg_ctrl_all` is set.
- R10: A frame that passes R2–R9 but has `frm_err` set is dropped when `cfg_err_discard` is set. Otherwise it is accepted with `dec_err_flag` high. `dec_err_flag` is never high with `dec_drop` or for a frame without `frm_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_promisc | input | 1 | Accept all data frames without address filtering |
| cfg_pause_fwd | input | 1 | Pass pause frames to the client |
| cfg_ctrl_all | input | 1 | Pass non-pause control frames |
| cfg_err_discard | input | 1 | Drop errored frames instead of flagging them |
| sta_wr_en | input | 1 | Station address word write strobe |
| sta_wr_sel | input | 1 | Station to write (0 or 1) |
| sta_wr_upper | input | 1 | 1: write address bits 47:32, 0: bits 31:0 |
| sta_wr_data | input | 32 | Station address word |
| hash_wr_en | input | 1 | Hash entry write strobe |
| hash_wr_cmd | input | 10 | Bits 8:0 entry index, bit 9 value to store |
| hash_clr_all | input | 1 | Clear the whole hash table |
| frm_valid | input | 1 | Frame summary present this cycle |
| frm_dst | input | 48 | Destination address, first octet in bits 47:40 |
| frm_is_ctrl | input | 1 | Frame is a MAC control frame |
| frm_opcode | input | 16 | Control opcode |
| frm_crc_hi | input | 9 | Frame CRC bits 31:23 (CRC shifted right by 23) |
| frm_err | input | 1 | Frame received with an error |
| dec_valid | output | 1 | Verdict present |
| dec_accept | output | 1 | Frame goes to the client |
| dec_drop | output | 1 | Frame is discarded |
| dec_err_flag | output | 1 | Accepted frame carries an error mark |

## Verification
The hardest state to reach from the ports is a specific hash table contents paired with a matching CRC index. Each of the 512 entries is reached only by writing it and then presenting a multicast frame whose upper CRC bits select it. The stimulus therefore walks every index: it sets the entry, checks a hit, clears the entry and checks a miss. It then loads a sparse pattern and compares all 512 lookups against a shadow copy, and finally issues a clear together with a write to show that the clear wins. The policy bits are swept over all sixteen combinations, against every frame class, with and without the error bit.

// File: rtl/rff_pkg.sv
// Shared types for the receive frame admission filter.
package rff_pkg;

    // Registered verdict for one frame.
    typedef struct packed {
        logic accept;
        logic drop;
        logic err_flag;
    } rff_verdict_t;

    // Address class of a data frame.
    typedef enum logic [1:0] {
        DST_UNICAST   = 2'd0,
        DST_MULTICAST = 2'd1,
        DST_BROADCAST = 2'd2
    } rff_dst_kind_t;

endpackage

// File: rtl/rff_station_bank.sv
// Bank of exact-match station addresses.
// Each address is written one word at a time: the low word covers bits
// WORD_W-1:0 and the high word the remaining ADDR_W-WORD_W bits. The bank
// compares the lookup address against every station and reports a hit on
// any match. Assumes ADDR_W > WORD_W and ADDR_W - WORD_W <= WORD_W.
module rff_station_bank #(
    parameter int ADDR_W       = 48,
    parameter int WORD_W       = 32,
    parameter int NUM_STATIONS = 2,
    parameter int SEL_W        = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic              wr_upper,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] lookup_addr,
    output logic              hit
);
    localparam int HI_W = ADDR_W - WORD_W;

    logic [NUM_STATIONS-1:0] match_vec;

    for (genvar g = 0; g < NUM_STATIONS; g++) begin : g_station
        logic [ADDR_W-1:0] addr_q;
        logic              sel_me;

        assign sel_me = wr_en && (wr_sel == SEL_W'(g));

        // Load the selected word of this station address.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                addr_q <= '0;
            end else if (sel_me) begin
                if (wr_upper) begin
                    addr_q[ADDR_W-1:WORD_W] <= wr_data[HI_W-1:0];
                end else begin
                    addr_q[WORD_W-1:0] <= wr_data;
                end
            end
        end

        // Compare the full address against this station.
        assign match_vec[g] = (addr_q == lookup_addr);
    end

    // Any station matching admits the frame.
    assign hit = |match_vec;

endmodule

// File: rtl/rff_hash_filter.sv
// Multicast hash table of 2**IDX_W single-bit entries.
// One entry is written per cycle, or the whole table is cleared; a clear
// overrides a write presented in the same cycle. Lookup is combinational
// on the current contents, so a write is visible from the next cycle on.
module rff_hash_filter #(
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_val,
    input  logic             clr_all,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_hit
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [ENTRIES-1:0] bits_q;

    // Clear, then single-entry update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else if (clr_all) begin
            bits_q <= '0;
        end else if (wr_en) begin
            bits_q[wr_idx] <= wr_val;
        end
    end

    // Read the entry selected by the frame's CRC bits.
    assign rd_hit = bits_q[rd_idx];

endmodule

// File: rtl/rff_policy.sv
// Combinational admission policy.
// Control frames bypass address filtering and follow the pause and
// command-frame policy bits. Data frames are admitted by promiscuous mode,
// by broadcast, by a hash hit (multicast) or by a station hit (unicast).
// The error rule is applied last, only to frames that would be admitted.
module rff_policy
    import rff_pkg::*;
(
    input  logic          is_ctrl,
    input  logic          is_pause,
    input  rff_dst_kind_t dst_kind,
    input  logic          station_hit,
    input  logic          hash_hit,
    input  logic          frm_err,
    input  logic          promisc,
    input  logic          pause_fwd,
    input  logic          ctrl_all,
    input  logic          err_discard,
    output rff_verdict_t  verdict
);
    logic addr_ok;
    logic ctrl_ok;
    logic admit;
    logic discard_err;

    // Address stage for data frames.
    always_comb begin
        unique case (dst_kind)
            DST_BROADCAST: addr_ok = 1'b1;
            DST_MULTICAST: addr_ok = promisc || hash_hit;
            default:       addr_ok = promisc || station_hit;
        endcase
    end

    // Control-frame stage and error rule.
    always_comb begin
        ctrl_ok          = is_pause ? pause_fwd : ctrl_all;
        admit            = is_ctrl ? ctrl_ok : addr_ok;
        discard_err      = frm_err && err_discard;
        verdict.accept   = admit && !discard_err;
        verdict.drop     = !(admit && !discard_err);
        verdict.err_flag = admit && !discard_err && frm_err;
    end

endmodule

// File: rtl/rx_frame_filter.sv
// Receive frame admission filter, top level.
// Classifies the destination address of each frame summary, looks it up
// in the station bank and the multicast hash table, applies the policy
// and registers the verdict, giving one cycle of latency. The first octet
// on the wire sits in the top byte of frm_dst, so its least significant
// bit (the group bit) is bit ADDR_W-8.
module rx_frame_filter
    import rff_pkg::*;
#(
    parameter int          ADDR_W       = 48,
    parameter int          WORD_W       = 32,
    parameter int          NUM_STATIONS = 2,
    parameter int          HASH_IDX_W   = 9,
    parameter int          OPC_W        = 16,
    parameter logic [15:0] PAUSE_OPCODE = 16'h0001,
    parameter int          SEL_W        = (NUM_STATIONS > 1) ? $clog2(NUM_STATIONS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_promisc,
    input  logic                  cfg_pause_fwd,
    input  logic                  cfg_ctrl_all,
    input  logic                  cfg_err_discard,
    input  logic                  sta_wr_en,
    input  logic [SEL_W-1:0]      sta_wr_sel,
    input  logic                  sta_wr_upper,
    input  logic [WORD_W-1:0]     sta_wr_data,
    input  logic                  hash_wr_en,
    input  logic [HASH_IDX_W:0]   hash_wr_cmd,
    input  logic                  hash_clr_all,
    input  logic                  frm_valid,
    input  logic [ADDR_W-1:0]     frm_dst,
    input  logic                  frm_is_ctrl,
    input  logic [OPC_W-1:0]      frm_opcode,
    input  logic [HASH_IDX_W-1:0] frm_crc_hi,
    input  logic                  frm_err,
    output logic                  dec_valid,
    output logic                  dec_accept,
    output logic                  dec_drop,
    output logic                  dec_err_flag
);
    localparam int GROUP_BIT = ADDR_W - 8;

    rff_dst_kind_t dst_kind;
    logic          station_hit;
    logic          hash_hit;
    logic          is_pause;
    rff_verdict_t  verdict;
    rff_verdict_t  verdict_q;
    logic          valid_q;

    // Classify the destination address.
    always_comb begin
        if (&frm_dst) begin
            dst_kind = DST_BROADCAST;
        end else if (frm_dst[GROUP_BIT]) begin
            dst_kind = DST_MULTICAST;
        end else begin
            dst_kind = DST_UNICAST;
        end
    end

    assign is_pause = (frm_opcode == OPC_W'(PAUSE_OPCODE));

    rff_station_bank #(
        .ADDR_W       (ADDR_W),
        .WORD_W       (WORD_W),
        .NUM_STATIONS (NUM_STATIONS),
        .SEL_W        (SEL_W)
    ) u_stations (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (sta_wr_en),
        .wr_sel      (sta_wr_sel),
        .wr_upper    (sta_wr_upper),
        .wr_data     (sta_wr_data),
        .lookup_addr (frm_dst),
        .hit         (station_hit)
    );

    rff_hash_filter #(
        .IDX_W (HASH_IDX_W)
    ) u_hash (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (hash_wr_en),
        .wr_idx  (hash_wr_cmd[HASH_IDX_W-1:0]),
        .wr_val  (hash_wr_cmd[HASH_IDX_W]),
        .clr_all (hash_clr_all),
        .rd_idx  (frm_crc_hi),
        .rd_hit  (hash_hit)
    );

    rff_policy u_policy (
        .is_ctrl     (frm_is_ctrl),
        .is_pause    (is_pause),
        .dst_kind    (dst_kind),
        .station_hit (station_hit),
        .hash_hit    (hash_hit),
        .frm_err     (frm_err),
        .promisc     (cfg_promisc),
        .pause_fwd   (cfg_pause_fwd),
        .ctrl_all    (cfg_ctrl_all),
        .err_discard (cfg_err_discard),
        .verdict     (verdict)
    );

    // Register the verdict; outputs idle low when no frame was presented.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q   <= 1'b0;
            verdict_q <= '0;
        end else begin
            valid_q   <= frm_valid;
            verdict_q <= frm_valid ? verdict : '0;
        end
    end

    assign dec_valid    = valid_q;
    assign dec_accept   = verdict_q.accept;
    assign dec_drop     = verdict_q.drop;
    assign dec_err_flag = verdict_q.err_flag;

endmodule

// File: rtl/rx_frame_filter_checker.sv
// Temporal checks on the filter's ports, bound into every instance.
module rx_frame_filter_checker #(
    parameter int          ADDR_W       = 48,
    parameter int          OPC_W        = 16,
    parameter logic [15:0] PAUSE_OPCODE = 16'h0001
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_promisc,
    input logic              cfg_pause_fwd,
    input logic              cfg_err_discard,
    input logic              frm_valid,
    input logic [ADDR_W-1:0] frm_dst,
    input logic              frm_is_ctrl,
    input logic [OPC_W-1:0]  frm_opcode,
    input logic              frm_err,
    input logic              dec_valid,
    input logic              dec_accept,
    input logic              dec_drop,
    input logic              dec_err_flag
);
    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid == $past(frm_valid && rst_n));

    assert_one_verdict_R1: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> (dec_accept != dec_drop));

    assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> !(dec_accept || dec_drop || dec_err_flag));

    assert_promisc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && frm_valid && cfg_promisc && !frm_is_ctrl && !frm_err) |-> dec_accept);

    assert_broadcast_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && frm_valid && !frm_is_ctrl && !frm_err && (&frm_dst)) |-> dec_accept);

    assert_pause_term_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && frm_valid && frm_is_ctrl && !cfg_pause_fwd &&
              (frm_opcode == OPC_W'(PAUSE_OPCODE))) |-> dec_drop);

    assert_err_discard_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && frm_valid && frm_err && cfg_err_discard) |-> dec_drop);

    assert_flag_needs_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dec_err_flag |-> (dec_accept && $past(frm_err)));

endmodule

bind rx_frame_filter rx_frame_filter_checker #(
    .ADDR_W       (ADDR_W),
    .OPC_W        (OPC_W),
    .PAUSE_OPCODE (PAUSE_OPCODE)
) u_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_promisc     (cfg_promisc),
    .cfg_pause_fwd   (cfg_pause_fwd),
    .cfg_err_discard (cfg_err_discard),
    .frm_valid       (frm_valid),
    .frm_dst         (frm_dst),
    .frm_is_ctrl     (frm_is_ctrl),
    .frm_opcode      (frm_opcode),
    .frm_err         (frm_err),
    .dec_valid       (dec_valid),
    .dec_accept      (dec_accept),
    .dec_drop        (dec_drop),
    .dec_err_flag    (dec_err_flag)
);

// File: tb/rx_frame_filter_bench.sv
`timescale 1ns/1ps
module rx_frame_filter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_promisc = 0, cfg_pause_fwd = 0, cfg_ctrl_all = 0, cfg_err_discard = 0;
    logic        sta_wr_en = 0;
    logic [0:0]  sta_wr_sel = 0;
    logic        sta_wr_upper = 0;
    logic [31:0] sta_wr_data = 0;
    logic        hash_wr_en = 0;
    logic [9:0]  hash_wr_cmd = 0;
    logic        hash_clr_all = 0;
    logic        frm_valid = 0;
    logic [47:0] frm_dst = 0;
    logic        frm_is_ctrl = 0;
    logic [15:0] frm_opcode = 0;
    logic [8:0]  frm_crc_hi = 0;
    logic        frm_err = 0;
    logic        dec_valid, dec_accept, dec_drop, dec_err_flag;

    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 0;
    bit          shadow [512];
    logic [47:0] st [2];

    localparam logic [47:0] MCAST_DST = 48'h01005E0000AB;
    localparam logic [47:0] BCAST_DST = 48'hFFFFFFFFFFFF;
    localparam logic [47:0] MISS_DST  = 48'h3C0000001234;

    always #2.5 clk = ~clk;

    rx_frame_filter u_rx_frame_filter (.*);

    // Independent expectation: {accept, drop, err_flag}.
    function automatic logic [2:0] expect_v(logic [47:0] dst, logic ctrl, logic [15:0] opc,
                                            logic [8:0] idx, logic err);
        logic pass;
        if (ctrl)                     pass = (opc == 16'h0001) ? cfg_pause_fwd : cfg_ctrl_all;
        else if (cfg_promisc)         pass = 1'b1;
        else if (dst == BCAST_DST)    pass = 1'b1;
        else if (dst[40])             pass = shadow[idx];
        else                          pass = (dst == st[0]) || (dst == st[1]);
        if (pass && !(err && cfg_err_discard)) return {1'b1, 1'b0, err};
        return 3'b010;
    endfunction

    task automatic check(string req, logic [3:0] act, logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {valid,acc,drop,flag} actual %b expected %b", req, act, exp);
        end
    endtask

    // Present one frame at a negedge and sample its verdict one cycle later.
    task automatic send(string req, logic [47:0] dst, logic ctrl, logic [15:0] opc,
                        logic [8:0] idx, logic err);
        logic [2:0] e;
        e = expect_v(dst, ctrl, opc, idx, err);
        frm_valid = 1; frm_dst = dst; frm_is_ctrl = ctrl; frm_opcode = opc;
        frm_crc_hi = idx; frm_err = err;
        @(negedge clk);
        frm_valid = 0;
        check(req, {dec_valid, dec_accept, dec_drop, dec_err_flag}, {1'b1, e});
    endtask

    task automatic hash_write(int idx, bit val);
        hash_wr_en = 1; hash_wr_cmd = {val, 9'(idx)};
        @(negedge clk);
        hash_wr_en = 0;
        shadow[idx] = val;
    endtask

    task automatic sta_write(int sel, bit upper, logic [31:0] data);
        sta_wr_en = 1; sta_wr_sel = 1'(sel); sta_wr_upper = upper; sta_wr_data = data;
        @(negedge clk);
        sta_wr_en = 0;
        if (upper) st[sel][47:32] = data[15:0];
        else       st[sel][31:0]  = data;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 512; i++) shadow[i] = 0;
        st[0] = '0; st[1] = '0;
        repeat (4) @(negedge clk);
        // R1: outputs idle in reset.
        check("R1 reset", {dec_valid, dec_accept, dec_drop, dec_err_flag}, 4'b0000);
        rst_n = 1;
        @(negedge clk);
        check("R1 idle after reset", {dec_valid, dec_accept, dec_drop, dec_err_flag}, 4'b0000);

        // R4: stations reset to zero; R5: hash resets empty.
        send("R4 reset station", 48'h0, 0, 16'h0, 9'd0, 0);
        send("R4 reset miss", MISS_DST, 0, 16'h0, 9'd0, 0);
        send("R5 reset hash", MCAST_DST, 0, 16'h0, 9'd5, 0);

        // Program stations and one hash entry.
        sta_write(0, 0, 32'h2C3D4E50); sta_write(0, 1, 32'hFFFF0A1B);
        sta_write(1, 0, 32'h00000007); sta_write(1, 1, 32'h00000200);
        hash_write(77, 1);
        send("R4 station0", 48'h0A1B2C3D4E50, 0, 16'h0, 9'd0, 0);
        send("R4 station1", 48'h020000000007, 0, 16'h0, 9'd0, 0);

        // Policy sweep: all cfg combinations x frame classes x error bit.
        for (int c = 0; c < 16; c++) begin
            {cfg_promisc, cfg_pause_fwd, cfg_ctrl_all, cfg_err_discard} = 4'(c);
            for (int e = 0; e < 2; e++) begin
                send("R8 pause",         MISS_DST, 1, 16'h0001, 9'd0, 1'(e));
                send("R9 other ctrl",    MISS_DST, 1, 16'h0101, 9'd0, 1'(e));
                send("R3 broadcast",     BCAST_DST, 0, 16'h0, 9'd3, 1'(e));
                send("R5 mcast hit",     MCAST_DST, 0, 16'h0, 9'd77, 1'(e));
                send("R5 mcast miss",    MCAST_DST, 0, 16'h0, 9'd78, 1'(e));
                send("R4 unicast st0",   st[0], 0, 16'h0, 9'd0, 1'(e));
                send("R4 unicast st1",   st[1], 0, 16'h0, 9'd0, 1'(e));
                send("R2 unicast miss",  MISS_DST, 0, 16'h0, 9'd0, 1'(e));
                send("R10 err bcast",    BCAST_DST, 0, 16'h0, 9'd0, 1'(e));
            end
        end
        {cfg_promisc, cfg_pause_fwd, cfg_ctrl_all, cfg_err_discard} = 4'b0000;

        // R6: walk every entry, set then clear.
        for (int i = 0; i < 512; i++) begin
            hash_write(i, 1);
            send("R6 set entry", MCAST_DST, 0, 16'h0, 9'(i), 0);
            hash_write(i, 0);
            send("R6 cleared entry", MCAST_DST, 0, 16'h0, 9'(i), 0);
        end

        // R5: sparse pattern, every index compared with the shadow.
        for (int i = 0; i < 512; i += 3) hash_write(i, 1);
        for (int i = 0; i < 512; i++) send("R5 pattern", MCAST_DST, 0, 16'h0, 9'(i), 0);

        // R7: clear-all together with a write; clear wins.
        hash_clr_all = 1; hash_wr_en = 1; hash_wr_cmd = {1'b1, 9'd1};
        @(negedge clk);
        hash_clr_all = 0; hash_wr_en = 0;
        for (int i = 0; i < 512; i++) shadow[i] = 0;
        for (int i = 0; i < 512; i++) send("R7 cleared", MCAST_DST, 0, 16'h0, 9'(i), 0);

        // R4: rewriting only the upper word moves station 0.
        sta_write(0, 1, 32'h00000C1B);
        send("R4 old station0", 48'h0A1B2C3D4E50, 0, 16'h0, 9'd0, 0);
        send("R4 new station0", 48'h0C1B2C3D4E50, 0, 16'h0, 9'd0, 0);

        // R10: flagged pass and discard on a matching unicast.
        cfg_err_discard = 0;
        send("R10 flag", st[1], 0, 16'h0, 9'd0, 1);
        cfg_err_discard = 1;
        send("R10 discard", st[1], 0, 16'h0, 9'd0, 1);
        @(negedge clk);
        check("R1 idle gap", {dec_valid, dec_accept, dec_drop, dec_err_flag}, 4'b0000);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule